// File: doc/BRIEF.md
# Two-Antenna Time-Reversed Diversity Encoder

This block feeds a two-transmit, one-receive diversity link. It takes a single stream of complex baseband symbols through a valid/ready handshake. It collects each group of symbols into a pair of equal-length data blocks, called A and B here, and plays every pair out as two bursts with no gap between them. Each burst drives two parallel antenna outputs.

In the first burst, antenna 1 carries block A and antenna 2 carries block B, both in their natural order. In the second burst, each block is read from its last sample to its first and conjugated. The blocks change antennas: antenna 1 carries the reversed, conjugated B with every sample negated, and antenna 2 carries the reversed, conjugated A. A `burst_id` output and a `burst_first` output mark each burst, so a downstream framer can insert guard intervals.

Storage is split into two banks that are used in turn. One pair is accepted while the previous pair is being transmitted. The block length is a run-time setting. It is captured once per pair, when the first symbol of that pair is accepted.

Top module: `trdiv_encoder`

## Requirements
- R1: While reset is asserted and directly after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: While `burst_id`=0 (the first burst), output sample k carries A[k] on antenna 1 and B[k] on antenna 2, for k = 0..L-1.
- R3: While `burst_id`=1 (the second burst), output sample k carries (-I, +Q) of B[L-1-k] on antenna 1.
- R4: While `burst_id`=1, output sample k carries (+I, -Q) of A[L-1-k] on antenna 2.
- R5: Every negation in R3 and R4 saturates: -32768 becomes 32767. As a result, the negated field of a second-burst output is never -32768.
- R6: `burst_id` is 0 for the L samples of the first burst and 1 for the L samples of the second burst. `burst_first` is 1 on the first sample of each burst and 0 on all other samples.
- R7: The 2L output samples of a pair appear on consecutive clock cycles. The second burst starts on the cycle right after the last sample of the first burst.
- R8: The block length L is `cfg_len`, clamped to the range 4..256. It is captured when the first symbol of a pair is accepted. Changing `cfg_len` later in the pair has no effect on that pair.
- R9: `in_ready` is 0 only while two complete pairs are stored and not yet fully transmitted. This lets the next pair be accepted while the current pair is being sent.
- R10: When the output side is idle, the first output sample of a pair appears 2 cycles after the clock edge that accepts the pair's last input symbol.
- R11: Suppose the next pair is complete at least one cycle before the last output sample of the current pair. Then that next pair's first sample follows on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 9 | Requested block length in samples; clamped to 4..256 |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block accepts a symbol on this edge |
| in_i | input | 16 | Input in-phase part, two's complement |
| in_q | input | 16 | Input quadrature part, two's complement |
| out_valid | output | 1 | Antenna samples valid this cycle |
| burst_id | output | 1 | 0 = first burst, 1 = second burst |
| burst_first | output | 1 | First sample of a burst |
| ant1_i | output | 16 | Antenna 1 in-phase |
| ant1_q | output | 16 | Antenna 1 quadrature |
| ant2_i | output | 16 | Antenna 2 in-phase |
| ant2_q | output | 16 | Antenna 2 quadrature |

## Verification
The bench samples on the falling edge and logs every accepted symbol. When a pair is complete, it builds the 2L expected output samples in a queue and compares each valid output against the head of that queue. It also has exact timing expectations:
- On an idle output side, the first sample must appear three falling edges after the sampling point of the last accepted symbol. That is the two register stages of R10.
- Once a pair has started, every following falling edge must show a valid sample until the pair ends.
- A waiting pair that completed at least two falling edges before the previous pair's last sample must follow that sample directly.

On every cycle, `in_ready` is compared with a count of stored pairs. A pair is added to that count on the edge that completes it and removed on the edge that outputs its last sample.

// File: rtl/trdiv_pkg.sv
package trdiv_pkg;
  parameter int SAMPLE_W = 16;

  typedef logic signed [SAMPLE_W-1:0] samp_t;

  typedef struct packed {
    samp_t re;
    samp_t im;
  } cplx_t;

  localparam samp_t SAMP_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam samp_t SAMP_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  typedef enum logic {
    BURST_FWD = 1'b0,
    BURST_REV = 1'b1
  } burst_e;

  // two's complement negation that pins the one unrepresentable result
  function automatic samp_t neg_sat(samp_t x);
    samp_t r;
    if (x == SAMP_MIN) r = SAMP_MAX;
    else               r = samp_t'(-x);
    return r;
  endfunction
endpackage

// File: rtl/trdiv_fill.sv
module trdiv_fill #(
  parameter int MAX_LEN = 256,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 9,
  parameter int PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             in_valid,
  input  logic [1:0]       bank_full,
  output logic             in_ready,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [PTR_W:0]   wr_addr,
  output logic             pair_done,
  output logic [LEN_W-1:0] pair_len
);
  logic             bank_q, bank_n;
  logic             blk_q, blk_n;
  logic [PTR_W-1:0] pos_q, pos_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] len_clamped, eff_len;
  logic             at_start, blk_end;

  always_comb begin
    if (cfg_len < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
    else if (cfg_len > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
    else                                len_clamped = cfg_len;

    at_start  = !blk_q && (pos_q == '0);
    eff_len   = at_start ? len_clamped : len_q;
    in_ready  = !bank_full[bank_q];
    wr_en     = in_valid && in_ready;
    blk_end   = (LEN_W'(pos_q) == eff_len - LEN_W'(1));
    pair_done = wr_en && blk_q && blk_end;
    pair_len  = eff_len;
    wr_bank   = bank_q;
    wr_addr   = {blk_q, pos_q};

    bank_n = bank_q;
    blk_n  = blk_q;
    pos_n  = pos_q;
    len_n  = len_q;
    if (wr_en) begin
      if (at_start) len_n = len_clamped;
      if (blk_end) begin
        pos_n = '0;
        blk_n = !blk_q;
        if (blk_q) bank_n = !bank_q;
      end else begin
        pos_n = pos_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      blk_q  <= 1'b0;
      pos_q  <= '0;
      len_q  <= LEN_W'(MIN_LEN);
    end else begin
      bank_q <= bank_n;
      blk_q  <= blk_n;
      pos_q  <= pos_n;
      len_q  <= len_n;
    end
  end
endmodule

// File: rtl/trdiv_store.sv
module trdiv_store
  import trdiv_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  cplx_t         wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output cplx_t         rd_a,
  output cplx_t         rd_b
);
  localparam int DEPTH = 1 << AW;

  cplx_t bank_rd_a [NBANK];
  cplx_t bank_rd_b [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cplx_t mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_bank) == b)) mem[wr_addr] <= wr_data;
    end
    assign bank_rd_a[b] = mem[rd_addr_a];
    assign bank_rd_b[b] = mem[rd_addr_b];
  end

  assign rd_a = bank_rd_a[rd_bank];
  assign rd_b = bank_rd_b[rd_bank];
endmodule

// File: rtl/trdiv_drain.sv
module trdiv_drain
  import trdiv_pkg::*;
#(
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 9,
  parameter int PTR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bank_full,
  input  logic [1:0][LEN_W-1:0] bank_len,
  output logic                  active,
  output burst_e                phase,
  output logic                  rd_bank,
  output logic [PTR_W-1:0]      rd_pos,
  output logic                  first,
  output logic                  done_pulse,
  output logic [LEN_W-1:0]      cur_len
);
  logic             act_q, act_n;
  burst_e           ph_q, ph_n;
  logic             bank_q, bank_n;
  logic [PTR_W-1:0] pos_q, pos_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] rev_idx;
  logic             burst_end;

  always_comb begin
    burst_end  = (LEN_W'(pos_q) == len_q - LEN_W'(1));
    rev_idx    = len_q - LEN_W'(1) - LEN_W'(pos_q);
    done_pulse = act_q && (ph_q == BURST_REV) && burst_end;

    act_n  = act_q;
    ph_n   = ph_q;
    bank_n = bank_q;
    pos_n  = pos_q;
    len_n  = len_q;
    if (!act_q) begin
      if (bank_full[bank_q]) begin
        act_n = 1'b1;
        ph_n  = BURST_FWD;
        pos_n = '0;
        len_n = bank_len[bank_q];
      end
    end else if (burst_end) begin
      pos_n = '0;
      if (ph_q == BURST_FWD) begin
        ph_n = BURST_REV;
      end else begin
        bank_n = !bank_q;
        ph_n   = BURST_FWD;
        act_n  = bank_full[!bank_q];
        len_n  = bank_len[!bank_q];
      end
    end else begin
      pos_n = pos_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= BURST_FWD;
      bank_q <= 1'b0;
      pos_q  <= '0;
      len_q  <= LEN_W'(MIN_LEN);
    end else begin
      act_q  <= act_n;
      ph_q   <= ph_n;
      bank_q <= bank_n;
      pos_q  <= pos_n;
      len_q  <= len_n;
    end
  end

  assign active  = act_q;
  assign phase   = ph_q;
  assign rd_bank = bank_q;
  assign rd_pos  = (ph_q == BURST_REV) ? rev_idx[PTR_W-1:0] : pos_q;
  assign first   = (pos_q == '0);
  assign cur_len = len_q;
endmodule

// File: rtl/trdiv_encoder.sv
module trdiv_encoder
  import trdiv_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                out_valid,
  output logic                burst_id,
  output logic                burst_first,
  output logic [SAMPLE_W-1:0] ant1_i,
  output logic [SAMPLE_W-1:0] ant1_q,
  output logic [SAMPLE_W-1:0] ant2_i,
  output logic [SAMPLE_W-1:0] ant2_q
);
  localparam int PTR_W = $clog2(MAX_LEN);
  localparam int AW    = PTR_W + 1;
  localparam int NBANK = 2;

  logic                      wr_en, wr_bank, pair_done;
  logic [AW-1:0]             wr_addr;
  logic [LEN_W-1:0]          pair_len;
  logic [NBANK-1:0]          full_q, full_n;
  logic [NBANK-1:0][LEN_W-1:0] blen_q, blen_n;
  logic                      dr_act, dr_bank, dr_first, dr_done;
  burst_e                    dr_phase;
  logic [PTR_W-1:0]          dr_pos;
  logic [LEN_W-1:0]          dr_len;
  cplx_t                     wr_data, rd_a, rd_b;
  cplx_t                     a1_n, a2_n;
  cplx_t                     a1_q, a2_q;
  logic                      ov_q, bid_q, bfirst_q;

  assign wr_data = '{re: samp_t'(in_i), im: samp_t'(in_q)};

  trdiv_fill #(
    .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .PTR_W(PTR_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .in_valid(in_valid),
    .bank_full(full_q), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .pair_done(pair_done),
    .pair_len(pair_len)
  );

  trdiv_store #(.NBANK(NBANK), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(dr_bank),
    .rd_addr_a({1'b0, dr_pos}), .rd_addr_b({1'b1, dr_pos}),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  trdiv_drain #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .bank_full(full_q), .bank_len(blen_q),
    .active(dr_act), .phase(dr_phase), .rd_bank(dr_bank), .rd_pos(dr_pos),
    .first(dr_first), .done_pulse(dr_done), .cur_len(dr_len)
  );

  // bank occupancy: set by the filler, cleared by the drainer
  always_comb begin
    full_n = full_q;
    blen_n = blen_q;
    if (pair_done) begin
      full_n[wr_bank] = 1'b1;
      blen_n[wr_bank] = pair_len;
    end
    if (dr_done) full_n[dr_bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      blen_q <= {NBANK{LEN_W'(MIN_LEN)}};
    end else begin
      full_q <= full_n;
      blen_q <= blen_n;
    end
  end

  // antenna mapping per burst
  always_comb begin
    if (dr_phase == BURST_FWD) begin
      a1_n = rd_a;
      a2_n = rd_b;
    end else begin
      a1_n = '{re: neg_sat(rd_b.re), im: rd_b.im};
      a2_n = '{re: rd_a.re, im: neg_sat(rd_a.im)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q     <= 1'b0;
      bid_q    <= 1'b0;
      bfirst_q <= 1'b0;
      a1_q     <= '0;
      a2_q     <= '0;
    end else begin
      ov_q <= dr_act;
      if (dr_act) begin
        bid_q    <= (dr_phase == BURST_REV);
        bfirst_q <= dr_first;
        a1_q     <= a1_n;
        a2_q     <= a2_n;
      end
    end
  end

  assign out_valid   = ov_q;
  assign burst_id    = bid_q;
  assign burst_first = bfirst_q;
  assign ant1_i      = a1_q.re;
  assign ant1_q      = a1_q.im;
  assign ant2_i      = a2_q.re;
  assign ant2_q      = a2_q.im;
endmodule

// File: rtl/trdiv_checker.sv
module trdiv_checker #(
  parameter int MAX_LEN  = 256,
  parameter int MIN_LEN  = 4,
  parameter int LEN_W    = 9,
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                burst_id,
  input logic                burst_first,
  input logic [SAMPLE_W-1:0] ant1_i,
  input logic [SAMPLE_W-1:0] ant2_q,
  input logic                drain_act,
  input logic [LEN_W-1:0]    drain_len
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!out_valid && in_ready);
    end
  end

  assert_no_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && burst_id) |-> (ant1_i != MOST_NEG && ant2_q != MOST_NEG));

  assert_second_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_id) |-> (out_valid && burst_first));

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !burst_id) |=> out_valid);

  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_act |-> (drain_len >= LEN_W'(MIN_LEN) && drain_len <= LEN_W'(MAX_LEN)));

  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
endmodule

bind trdiv_encoder trdiv_checker #(
  .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .SAMPLE_W(trdiv_pkg::SAMPLE_W)
) u_trdiv_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .burst_id(burst_id), .burst_first(burst_first), .ant1_i(ant1_i),
  .ant2_q(ant2_q), .drain_act(dr_act), .drain_len(dr_len)
);

// File: tb/trdiv_encoder_bench.sv
module trdiv_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  cfg_len;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_i, in_q;
  logic        out_valid, burst_id, burst_first;
  logic [15:0] ant1_i, ant1_q, ant2_i, ant2_q;

  always #4 clk = ~clk;

  trdiv_encoder u_trdiv_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .burst_id(burst_id), .burst_first(burst_first), .ant1_i(ant1_i),
    .ant1_q(ant1_q), .ant2_i(ant2_i), .ant2_q(ant2_q)
  );

  typedef struct {
    int a1i, a1q, a2i, a2q;
    bit bid, first, lastp;
    int pushc, due;
  } exp_t;

  exp_t  expq[$];
  int    col_i[$], col_q[$];
  int    m_len, full_cnt, cyc, checks, failures, seed;
  bit    must_valid;
  string must_tag, ctx;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", msg, ctx);
    end
  endtask

  function automatic int nsat(int x);
    return (x == -32768) ? 32767 : -x;
  endfunction

  function automatic int clampl(int c);
    return (c < 4) ? 4 : ((c > 256) ? 256 : c);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R7 watchdog expired: actual queue=%0d expected 0", expq.size());
      finish_run();
    end
  end

  // reference model and monitor, all on the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (must_valid)
        chk(out_valid, $sformatf("%s continuity: actual out_valid=%0b expected 1", must_tag, out_valid));
      must_valid = 1'b0;
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected sample: actual out_valid=1 expected 0");
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk($signed(ant1_i) == e.a1i && $signed(ant1_q) == e.a1q,
              $sformatf("%s ant1: actual (%0d,%0d) expected (%0d,%0d)", e.bid ? "R3 R5" : "R2",
                        $signed(ant1_i), $signed(ant1_q), e.a1i, e.a1q));
          chk($signed(ant2_i) == e.a2i && $signed(ant2_q) == e.a2q,
              $sformatf("%s ant2: actual (%0d,%0d) expected (%0d,%0d)", e.bid ? "R4 R5" : "R2",
                        $signed(ant2_i), $signed(ant2_q), e.a2i, e.a2q));
          chk(burst_id == e.bid && burst_first == e.first,
              $sformatf("R6 marks: actual id=%0b first=%0b expected id=%0b first=%0b",
                        burst_id, burst_first, e.bid, e.first));
          if (e.due != 0)
            chk(cyc == e.due, $sformatf("R10 latency: actual cycle %0d expected %0d", cyc, e.due));
          if (!e.lastp) begin
            must_valid = 1'b1;
            must_tag   = "R7";
          end else begin
            full_cnt--;
            if (expq.size() != 0 && expq[0].pushc <= cyc - 2) begin
              must_valid = 1'b1;
              must_tag   = "R11";
            end
          end
        end
      end
      chk(in_ready == (full_cnt < 2),
          $sformatf("R9 ready: actual %0b expected %0b", in_ready, full_cnt < 2));
      if (in_valid && in_ready) begin
        if (col_i.size() == 0) m_len = clampl(int'(cfg_len));
        col_i.push_back($signed(in_i));
        col_q.push_back($signed(in_q));
        if (col_i.size() == 2 * m_len) begin
          bit idle;
          idle = (expq.size() == 0) && !out_valid;
          for (int k = 0; k < m_len; k++) begin
            exp_t e;
            e.a1i = col_i[k];          e.a1q = col_q[k];
            e.a2i = col_i[m_len + k];  e.a2q = col_q[m_len + k];
            e.bid = 1'b0; e.first = (k == 0); e.lastp = 1'b0;
            e.pushc = cyc; e.due = (idle && k == 0) ? cyc + 3 : 0;
            expq.push_back(e);
          end
          for (int k = 0; k < m_len; k++) begin
            exp_t e;
            int   r;
            r = m_len - 1 - k;
            e.a1i = nsat(col_i[m_len + r]); e.a1q = col_q[m_len + r];
            e.a2i = col_i[r];               e.a2q = nsat(col_q[r]);
            e.bid = 1'b1; e.first = (k == 0); e.lastp = (k == m_len - 1);
            e.pushc = cyc; e.due = 0;
            expq.push_back(e);
          end
          col_i.delete();
          col_q.delete();
          full_cnt++;
        end
      end
    end
  end

  task automatic send_sym(input int i, input int q);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    while (!in_ready) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_rand(input int n, input int gap_every);
    for (int s = 0; s < n; s++) begin
      seed = seed * 1103515245 + 12345;
      send_sym($signed(16'(seed >>> 8)), $signed(16'(seed >>> 15)));
      if (gap_every != 0 && (s % gap_every) == gap_every - 1) begin
        @(posedge clk); #1;
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic drain_wait();
    while (expq.size() != 0 || col_i.size() != 0) begin
      @(posedge clk); #1;
    end
    repeat (4) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    cyc = 0; checks = 0; failures = 0; full_cnt = 0; seed = 7;
    must_valid = 1'b0; ctx = "";
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; cfg_len = 9'd4;
    repeat (3) @(negedge clk);
    chk(!out_valid, $sformatf("R1 reset: actual out_valid=%0b expected 0", out_valid));
    chk(in_ready, $sformatf("R1 reset: actual in_ready=%0b expected 1", in_ready));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready,
        $sformatf("R1 after release: actual valid=%0b ready=%0b expected 0 1", out_valid, in_ready));
    @(posedge clk); #1;

    // R2 R3 R4 R5 R10: extreme values in a minimum-length pair
    ctx = "(pair extremes R5)";
    cfg_len = 9'd4;
    send_sym(-32768, -32768); send_sym(32767, 32767); send_sym(0, -1); send_sym(5, -7);
    send_sym(-32768, 100);    send_sym(1, -32768);    send_sym(-1, 0); send_sym(123, -456);
    drain_wait();

    ctx = "(len 8 with input gaps)";
    cfg_len = 9'd8;
    send_rand(16, 3);
    drain_wait();

    ctx = "(R8 clamp low)";
    cfg_len = 9'd2;
    send_rand(8, 0);
    drain_wait();

    ctx = "(R8 clamp high)";
    cfg_len = 9'd300;
    send_rand(512, 0);
    drain_wait();

    ctx = "(R8 change inside pair)";
    cfg_len = 9'd6;
    send_rand(1, 0);
    cfg_len = 9'd12;
    send_rand(11, 0);
    drain_wait();

    ctx = "(R9 R11 streaming)";
    cfg_len = 9'd16;
    send_rand(5 * 32, 0);
    cfg_len = 9'd4;  send_rand(8, 0);
    cfg_len = 9'd10; send_rand(20, 0);
    cfg_len = 9'd4;  send_rand(8, 0);
    drain_wait();

    ctx = "(idle tail)";
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule